// File: doc/BRIEF.md
# Leader-to-Follower Branch Outcome Queue

This block sits between two cores that run the same program, one ahead of the other. The leading core retires its instructions into the block. Each retired branch is turned into a 3-bit record. A record whose skip bit is set also carries a reconvergent PC. Records wait in a first-in, first-out queue until the trailing core fetches the matching branch. For pre-executed branches, a per-register poison tracker on the push side checks whether the branch's inputs come from a load that the leader turned into a prefetch. If they do, the branch is downgraded to a discarded record.

On the pop side, a helper serves the follower's fetch stage. For each fetched branch it produces a prediction override, or no override when the follower must predict the branch itself. It also tracks gaps: stretches of the instruction stream that the leader skipped, running from a branch up to its reconvergent PC. While the follower is inside a gap, its branches consume no records.

The helper keeps, in fetch order, the outcomes it handed out. It compares each one against the follower's resolved direction. A mismatch, or a queue that fills up while the follower is still inside a gap, raises a one-cycle leader restart request. At the same clock edge, the block empties the queue, clears all poison bits and drops any open gap.

Top module: `branch_outcome_queue`

## Requirements
- R1: After reset the queue is empty, no register is poisoned, no gap is open, `restart` is low and `q_full` is low.
- R2: Retire op codes are: 0 plain, 1 prefetch-converted load, 2 normal branch, 3 pre-executed branch, 4 discarded branch. A record is {executed, outcome, skip}. A normal branch is pushed as {1, taken, 0}. When the follower fetches the next branch outside a gap, that record is popped and the branch gets `ovr_valid`=1 with `ovr_taken`=outcome, and no gap opens.
- R3: A pre-executed branch with no poisoned source is pushed as {1, taken, 1} with its reconvergent PC. When it is popped, the follower gets the outcome as an override and a gap opens. Branches fetched inside the gap get `ovr_valid`=0 and `fol_wait`=0, and they consume no record.
- R4: A discarded branch is pushed as {0, 0, 1} with its reconvergent PC. When it is popped, the follower gets `ovr_valid`=0 and a gap opens.
- R5: A gap closes when an instruction whose PC equals the stored reconvergent PC is fetched. If that instruction is a branch, it pops the next record in the same cycle.
- R6: A prefetch-converted load poisons its destination register. A plain instruction that writes a register copies into it the OR of its two sources' poison bits. A pre-executed branch with a poisoned source is pushed as {0, 0, 1}.
- R7: Records leave in push order. The queue holds DEPTH (256) records. `q_full` is high while it holds DEPTH records, and a push while full is dropped.
- R8: A branch fetched outside a gap while the queue is empty gets `fol_wait`=1 and `ovr_valid`=0, and it consumes nothing.
- R9: Resolved branches are matched in fetch order with the branches that were handed a prediction decision. If a resolved direction differs from an override that was used, `restart` rises in the next cycle. Resolving a branch that got no override never causes a restart.
- R10: If the queue is full while a gap is open, `restart` rises in the next cycle.
- R11: `restart` lasts one cycle. At the edge that raises it, the queue, all poison bits, the open gap and the pending-outcome list are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | Leader retires one instruction this cycle |
| ret_op | input | 3 | Retire op code (see R2) |
| ret_src_a | input | $clog2(NREG) | First source register |
| ret_src_b | input | $clog2(NREG) | Second source register |
| ret_dst | input | $clog2(NREG) | Destination register |
| ret_dst_we | input | 1 | Plain instruction writes `ret_dst` |
| ret_taken | input | 1 | Branch outcome from the leader |
| ret_rpc | input | PC_W | Reconvergent PC of the branch |
| q_full | output | 1 | Queue full; the leader must hold its branch |
| fetch_valid | input | 1 | Follower fetches one instruction |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_is_br | input | 1 | Fetched instruction is a conditional branch |
| ovr_valid | output | 1 | Use `ovr_taken` instead of the follower's own prediction |
| ovr_taken | output | 1 | Override direction |
| fol_wait | output | 1 | Follower branch must stall; no record is available yet |
| res_valid | input | 1 | Follower resolves its oldest pending branch |
| res_taken | input | 1 | Resolved direction |
| restart | output | 1 | One-cycle leader squash-and-restart request |

## Verification
The bench probes the gap boundaries. It checks that a branch inside a gap neither stalls nor steals a record; a design that got this wrong would misalign every later override. It also checks that a branch sitting exactly at the reconvergent PC pops a record; a design that got this wrong would leave the follower one record behind. The poison chain (load, then a plain instruction, then the branch) is exercised both with and without a clean overwrite, to catch trackers that never clear or never propagate. The bench also fills the queue exactly and pushes once more, then drains it, to catch off-by-one full logic and silent overwrites. The restart tests check that a resolve without an override stays quiet, that a mismatch or a gap with a full queue fires exactly one pulse, and that afterwards stale records and stale poison are gone.

// File: rtl/bq_pkg.sv
// Shared types for the branch outcome queue.
package bq_pkg;
    typedef enum logic [2:0] {
        OP_PLAIN   = 3'd0,
        OP_PFLOAD  = 3'd1,
        OP_BR_NORM = 3'd2,
        OP_BR_PRE  = 3'd3,
        OP_BR_DISC = 3'd4
    } ret_op_e;

    typedef struct packed {
        logic exec;     // leader executed the branch
        logic outcome;  // direction when exec is set
        logic skip;     // a gap follows up to the reconvergent PC
    } brcode_t;
endpackage

// File: rtl/bq_poison.sv
// Push-side encoder with register poison tracking.
// Assumes one retired instruction per cycle and a leader that holds
// its branch while the queue is full.
module bq_poison
    import bq_pkg::*;
#(
    parameter int NREG = 32,
    parameter int PC_W = 16,
    localparam int RIX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            ret_valid,
    input  logic [2:0]      ret_op,
    input  logic [RIX-1:0]  ret_src_a,
    input  logic [RIX-1:0]  ret_src_b,
    input  logic [RIX-1:0]  ret_dst,
    input  logic            ret_dst_we,
    input  logic            ret_taken,
    input  logic [PC_W-1:0] ret_rpc,
    output logic            push_valid,
    output brcode_t         push_code,
    output logic [PC_W-1:0] push_rpc,
    output logic [NREG-1:0] poison_bits
);
    logic    src_hot;
    ret_op_e op;

    assign op      = ret_op_e'(ret_op);
    assign src_hot = poison_bits[ret_src_a] | poison_bits[ret_src_b];

    // Build the branch record for this retired instruction.
    always_comb begin
        push_valid = 1'b0;
        push_code  = '0;
        case (op)
            OP_BR_NORM: begin
                push_valid = ret_valid;
                push_code  = '{exec: 1'b1, outcome: ret_taken, skip: 1'b0};
            end
            OP_BR_PRE: begin
                push_valid = ret_valid;
                push_code  = src_hot ? '{exec: 1'b0, outcome: 1'b0, skip: 1'b1}
                                     : '{exec: 1'b1, outcome: ret_taken, skip: 1'b1};
            end
            OP_BR_DISC: begin
                push_valid = ret_valid;
                push_code  = '{exec: 1'b0, outcome: 1'b0, skip: 1'b1};
            end
            default: ;
        endcase
        push_rpc = push_code.skip ? ret_rpc : '0;
    end

    // Track which registers hold values derived from a prefetched load.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            poison_bits <= '0;
        end else if (ret_valid) begin
            if (op == OP_PFLOAD)
                poison_bits[ret_dst] <= 1'b1;
            else if (op == OP_PLAIN && ret_dst_we)
                poison_bits[ret_dst] <= src_hot;
        end
    end
endmodule

// File: rtl/bq_fifo.sv
// Record storage: a circular buffer with an occupancy count.
// Assumes DEPTH is a power of two, at least 2. Pushes while full and
// pops while empty are ignored.
module bq_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 19,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};
        end
    end

    // Write the accepted record into storage.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/bq_consumer.sv
// Follower-side helper: turns records into overrides, tracks gaps and
// checks resolved directions. Assumes the follower fetches at most one
// instruction per cycle, resolves branches in fetch order and keeps no
// more than PEND branches unresolved.
module bq_consumer
    import bq_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int PEND = 16,
    localparam int PW  = $clog2(PEND)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_is_br,
    input  logic            head_valid,
    input  brcode_t         head_code,
    input  logic [PC_W-1:0] head_rpc,
    input  logic            res_valid,
    input  logic            res_taken,
    output logic            pop,
    output logic            ovr_valid,
    output logic            ovr_taken,
    output logic            fol_wait,
    output logic            in_gap,
    output logic            mismatch
);
    logic [PC_W-1:0] gap_rpc;
    logic            gap_hit, gap_now, br, br_go;
    logic [PEND-1:0] pend_used, pend_dir;
    logic [PW-1:0]   pw_ptr, pr_ptr;
    logic [PW:0]     pend_cnt;
    logic            pend_push, pend_pop;

    // Decide, per fetched branch, between the queue, a gap and a stall.
    always_comb begin
        gap_hit   = in_gap && fetch_valid && (fetch_pc == gap_rpc);
        gap_now   = in_gap && !gap_hit;
        br        = fetch_valid && fetch_is_br;
        pop       = br && !gap_now && head_valid;
        fol_wait  = br && !gap_now && !head_valid;
        br_go     = br && !fol_wait;
        ovr_valid = pop && head_code.exec;
        ovr_taken = ovr_valid && head_code.outcome;
        pend_push = br_go && (pend_cnt != (PW+1)'(PEND));
        pend_pop  = res_valid && (pend_cnt != '0);
        mismatch  = pend_pop && pend_used[pr_ptr] && (pend_dir[pr_ptr] != res_taken);
    end

    // Open a gap on a popped skip record, close it at the reconvergent PC.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            in_gap  <= 1'b0;
            gap_rpc <= '0;
        end else if (pop && head_code.skip) begin
            in_gap  <= 1'b1;
            gap_rpc <= head_rpc;
        end else if (gap_hit) begin
            in_gap  <= 1'b0;
        end
    end

    // Keep the order of pending branch decisions.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pw_ptr   <= '0;
            pr_ptr   <= '0;
            pend_cnt <= '0;
        end else begin
            if (pend_push) pw_ptr <= pw_ptr + 1'b1;
            if (pend_pop)  pr_ptr <= pr_ptr + 1'b1;
            pend_cnt <= pend_cnt + {{PW{1'b0}}, pend_push} - {{PW{1'b0}}, pend_pop};
        end
    end

    // Store whether each pending branch used an override, and its value.
    always_ff @(posedge clk) begin
        if (pend_push) begin
            pend_used[pw_ptr] <= ovr_valid;
            pend_dir[pw_ptr]  <= ovr_taken;
        end
    end
endmodule

// File: rtl/branch_outcome_queue.sv
// Top level: carries branch records from the leading core to the trailing
// core and requests a leader restart on a wrong override or when the
// queue fills during a gap. Every record stores a reconvergent PC field,
// which is zero unless the skip bit is set.
module branch_outcome_queue
    import bq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PC_W  = 16,
    parameter int NREG  = 32,
    parameter int PEND  = 16,
    localparam int RIX  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    input  logic [2:0]      ret_op,
    input  logic [RIX-1:0]  ret_src_a,
    input  logic [RIX-1:0]  ret_src_b,
    input  logic [RIX-1:0]  ret_dst,
    input  logic            ret_dst_we,
    input  logic            ret_taken,
    input  logic [PC_W-1:0] ret_rpc,
    output logic            q_full,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_is_br,
    output logic            ovr_valid,
    output logic            ovr_taken,
    output logic            fol_wait,
    input  logic            res_valid,
    input  logic            res_taken,
    output logic            restart
);
    localparam int W  = 3 + PC_W;
    localparam int CW = $clog2(DEPTH + 1);

    logic            flush, push_valid, q_empty, pop, in_gap, mismatch;
    brcode_t         push_code, head_code;
    logic [PC_W-1:0] push_rpc, head_rpc;
    logic [W-1:0]    head_word;
    logic [CW-1:0]   q_count;
    logic [NREG-1:0] poison_bits;

    assign flush     = mismatch || (in_gap && q_full);
    assign head_code = head_word[W-1 -: 3];
    assign head_rpc  = head_word[PC_W-1:0];

    bq_poison #(.NREG(NREG), .PC_W(PC_W)) u_poison (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ret_valid(ret_valid), .ret_op(ret_op),
        .ret_src_a(ret_src_a), .ret_src_b(ret_src_b),
        .ret_dst(ret_dst), .ret_dst_we(ret_dst_we),
        .ret_taken(ret_taken), .ret_rpc(ret_rpc),
        .push_valid(push_valid), .push_code(push_code),
        .push_rpc(push_rpc), .poison_bits(poison_bits)
    );

    bq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push_valid), .din({push_code, push_rpc}),
        .pop(pop), .head(head_word),
        .empty(q_empty), .full(q_full), .count(q_count)
    );

    bq_consumer #(.PC_W(PC_W), .PEND(PEND)) u_cons (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_is_br(fetch_is_br),
        .head_valid(!q_empty), .head_code(head_code), .head_rpc(head_rpc),
        .res_valid(res_valid), .res_taken(res_taken),
        .pop(pop), .ovr_valid(ovr_valid), .ovr_taken(ovr_taken),
        .fol_wait(fol_wait), .in_gap(in_gap), .mismatch(mismatch)
    );

    // Register the restart request as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) restart <= 1'b0;
        else        restart <= flush;
    end
endmodule

// File: rtl/bq_checker.sv
// Assertion checker for branch_outcome_queue, attached by bind.
module bq_checker #(
    parameter int DEPTH = 256,
    parameter int NREG  = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            restart,
    input logic            q_full,
    input logic            fol_wait,
    input logic            ovr_valid,
    input logic [CW-1:0]   q_count,
    input logic            in_gap,
    input logic [NREG-1:0] poison_bits
);
    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && q_count != $past(q_count)) |->
        (q_count == $past(q_count) + 1'b1 || q_count + 1'b1 == $past(q_count)));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

    // R8
    wait_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fol_wait |-> !ovr_valid);

    // R2
    ovr_needs_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> q_count != '0);

    // R10
    full_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && q_full && !restart) |=> restart);

    // R11
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    // R11
    flush_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (q_count == '0 && poison_bits == '0 && !in_gap));
endmodule

bind branch_outcome_queue bq_checker #(.DEPTH(DEPTH), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .q_full(q_full),
    .fol_wait(fol_wait), .ovr_valid(ovr_valid), .q_count(q_count),
    .in_gap(in_gap), .poison_bits(poison_bits)
);

// File: tb/tb_branch_outcome_queue.sv
module tb_branch_outcome_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid, ret_dst_we, ret_taken;
    logic [2:0]  ret_op;
    logic [4:0]  ret_src_a, ret_src_b, ret_dst;
    logic [15:0] ret_rpc, fetch_pc;
    logic        fetch_valid, fetch_is_br, res_valid, res_taken;
    logic        q_full, ovr_valid, ovr_taken, fol_wait, restart;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #5 clk = ~clk;

    branch_outcome_queue dut (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_op(ret_op),
        .ret_src_a(ret_src_a), .ret_src_b(ret_src_b), .ret_dst(ret_dst),
        .ret_dst_we(ret_dst_we), .ret_taken(ret_taken), .ret_rpc(ret_rpc),
        .q_full(q_full),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_is_br(fetch_is_br),
        .ovr_valid(ovr_valid), .ovr_taken(ovr_taken), .fol_wait(fol_wait),
        .res_valid(res_valid), .res_taken(res_taken), .restart(restart)
    );

    // Vector: {op[2:0], taken, rpc[15:0], exp_ovr_valid, exp_ovr_taken, exp_gap}
    localparam logic [22:0] VEC [6] = '{
        {3'd2, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0},
        {3'd2, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
        {3'd3, 1'b1, 16'h0140, 1'b1, 1'b1, 1'b1},
        {3'd3, 1'b0, 16'h0180, 1'b1, 1'b0, 1'b1},
        {3'd4, 1'b1, 16'h01C0, 1'b0, 1'b0, 1'b1},
        {3'd2, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ret_valid = 1'b0; ret_dst_we = 1'b0; ret_taken = 1'b0; ret_op = 3'd0;
        ret_src_a = '0; ret_src_b = '0; ret_dst = '0; ret_rpc = '0;
        fetch_valid = 1'b0; fetch_is_br = 1'b0; fetch_pc = '0;
        res_valid = 1'b0; res_taken = 1'b0;
    endtask

    task automatic lead(input logic [2:0] op, input logic t, input logic [4:0] a,
                        input logic [4:0] b, input logic [4:0] d, input logic we,
                        input logic [15:0] rpc);
        ret_valid = 1'b1; ret_op = op; ret_taken = t; ret_src_a = a;
        ret_src_b = b; ret_dst = d; ret_dst_we = we; ret_rpc = rpc;
    endtask

    task automatic fetch(input logic [15:0] pc, input logic isbr);
        fetch_valid = 1'b1; fetch_pc = pc; fetch_is_br = isbr;
        #3;
    endtask

    task automatic resolve(input logic t);
        res_valid = 1'b1; res_taken = t;
        tick();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        #3;
        chk("R1 restart", restart, 0);
        chk("R1 q_full", q_full, 0);
        fetch(16'h0010, 1'b1);
        chk("R1 empty queue stalls", fol_wait, 1);
        chk("R1 no override", ovr_valid, 0);
        tick();

        // Vector table: R2, R3, R4, R5, R8, R9
        for (int v = 0; v < 6; v++) begin
            logic [2:0]  op;
            logic        t, ev, et, eg;
            logic [15:0] rpc;
            {op, t, rpc, ev, et, eg} = VEC[v];
            lead(op, t, 5'd0, 5'd0, 5'd0, 1'b0, rpc);
            tick();
            fetch(16'h0100, 1'b1);
            chk("R2 R3 R4 override valid", ovr_valid, ev);
            chk("R2 R3 R4 override dir", ovr_taken, et);
            chk("R2 no stall", fol_wait, 0);
            tick();
            resolve(ev ? et : 1'b0);
            chk("R9 matching resolve", restart, 0);
            if (eg) begin
                fetch(16'h0104, 1'b1);
                chk("R3 gap branch no override", ovr_valid, 0);
                chk("R3 gap branch no stall", fol_wait, 0);
                tick();
                resolve(1'b1);
                chk("R9 unused resolve", restart, 0);
                fetch(rpc, 1'b0);
                tick();
            end
            fetch(16'h0108, 1'b1);
            chk("R8 R5 out of gap and empty", fol_wait, 1);
            chk("R8 no override", ovr_valid, 0);
            tick();
        end

        // R6: poison chain load -> plain -> pre-executed branch
        lead(3'd1, 1'b0, 5'd0, 5'd0, 5'd3, 1'b1, 16'h0);
        tick();
        lead(3'd0, 1'b0, 5'd3, 5'd0, 5'd5, 1'b1, 16'h0);
        tick();
        lead(3'd3, 1'b1, 5'd5, 5'd0, 5'd0, 1'b0, 16'h02A0);
        tick();
        lead(3'd2, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0);
        tick();
        fetch(16'h0200, 1'b1);
        chk("R6 poisoned branch downgraded", ovr_valid, 0);
        chk("R6 no stall", fol_wait, 0);
        tick();
        resolve(1'b0);
        // R5: branch at the reconvergent PC pops the next record
        fetch(16'h02A0, 1'b1);
        chk("R5 branch at rpc valid", ovr_valid, 1);
        chk("R5 branch at rpc dir", ovr_taken, 1);
        tick();
        resolve(1'b1);
        chk("R9 no restart", restart, 0);
        // R6: clean overwrite clears poison of r5
        lead(3'd0, 1'b0, 5'd0, 5'd0, 5'd5, 1'b1, 16'h0);
        tick();
        lead(3'd3, 1'b0, 5'd5, 5'd0, 5'd0, 1'b0, 16'h02C0);
        tick();
        fetch(16'h0210, 1'b1);
        chk("R6 cleared poison keeps pre-exec", ovr_valid, 1);
        chk("R6 pre-exec dir", ovr_taken, 0);
        tick();
        resolve(1'b0);
        fetch(16'h02C0, 1'b0);
        tick();

        // R9: mismatch on a used override; R11 flush
        lead(3'd2, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0);
        tick();
        lead(3'd2, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0);
        tick();
        fetch(16'h0300, 1'b1);
        chk("R9 override used", ovr_valid, 1);
        tick();
        #3;
        chk("R9 no restart before resolve", restart, 0);
        resolve(1'b0);
        chk("R9 mismatch restart", restart, 1);
        fetch(16'h0304, 1'b1);
        chk("R11 queue flushed", fol_wait, 1);
        tick();
        chk("R11 single pulse", restart, 0);
        // R11: r3 was poisoned before the restart
        lead(3'd3, 1'b1, 5'd3, 5'd0, 5'd0, 1'b0, 16'h0330);
        tick();
        fetch(16'h0310, 1'b1);
        chk("R11 poison cleared", ovr_valid, 1);
        tick();
        resolve(1'b1);
        fetch(16'h0330, 1'b0);
        tick();

        // R7: exact fill, dropped push, in-order drain
        for (int i = 0; i < 256; i++) begin
            lead(3'd2, i[0], 5'd0, 5'd0, 5'd0, 1'b0, 16'h0);
            tick();
        end
        #3;
        chk("R7 full at depth", q_full, 1);
        lead(3'd2, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0);
        tick();
        for (int i = 0; i < 256; i++) begin
            fetch(16'h0400, 1'b1);
            chk("R7 drain valid", ovr_valid, 1);
            chk("R7 drain order", ovr_taken, i[0]);
            tick();
            if (i == 0) chk("R7 not full after pop", q_full, 0);
        end
        fetch(16'h0404, 1'b1);
        chk("R7 push while full dropped", fol_wait, 1);
        tick();

        // R10: queue fills while a gap is open
        lead(3'd3, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0500);
        tick();
        fetch(16'h0410, 1'b1);
        chk("R10 gap opened by override", ovr_valid, 1);
        tick();
        for (int i = 0; i < 256; i++) begin
            lead(3'd2, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 16'h0);
            tick();
        end
        chk("R10 restart not yet", restart, 0);
        tick();
        chk("R10 full in gap restart", restart, 1);
        chk("R11 full cleared", q_full, 0);
        tick();
        chk("R11 pulse ends", restart, 0);
        fetch(16'h0420, 1'b1);
        chk("R11 gap dropped and queue empty", fol_wait, 1);
        tick();

        finish_run();
    end
endmodule